// File: doc/BRIEF.md
# Configuration Access Translator

This block sits between a host register port and a 32-bit memory-style request/response port. It turns configuration read and write requests into a short sequence of word accesses. Each request carries a bus, device and function number, a byte offset, an access size and write data. The block first classifies the target by comparing its bus number with the root bus number. The target is either the root port's own register space, a device on the bus directly below the root, or a device further downstream.

For every accepted request, the block first selects outbound translation region 0 and then programs the request type. For targets below the root port it also loads the target identifier, and then it reaches the data word. A data word on the root bus is read from the controller register space. Any other data word is read through the configuration window. Requests to a non-zero device number on the root bus or on the bus directly below it cannot be reached, so they are filtered out without touching memory. Sub-word writes are carried out as read, merge, write. Only one request is handled at a time.

Top module: `cfg_xlate`

## Requirements
- R1: A request whose bus equals the root bus writes the type register with 5. It writes no target register. It then accesses the word at CTRL_BASE plus the offset with its two low bits cleared.
- R2: A request whose bus equals the root bus plus one (modulo 256) writes 4, the type 0 code, to the type register.
- R3: A request to any other bus writes 5, the type 1 code, to the type register.
- R4: A request to a bus other than the root bus writes the target register at CTRL_BASE+TARGET_OFF with bus in bits 31:24, device in bits 23:19 and function in bits 18:16, all other bits zero. This write comes before the data access.
- R5: Every request that is not rejected starts with a write of 0 to CTRL_BASE+VPORT_OFF, which selects outbound region 0. The type register write at CTRL_BASE+TYPE_OFF follows it.
- R6: A request with a non-zero device number on the root bus, or on the root bus plus one, makes no memory access. It responds in the cycle after acceptance. A rejected read returns all ones of its size (size 0 gives 0xFF, size 1 gives 0xFFFF, size 2 gives 0xFFFFFFFF) and a rejected write is dropped.
- R7: The data access for a bus other than the root bus uses WIN_BASE plus the offset with its two low bits cleared.
- R8: A write of size 0 (byte) or size 1 (halfword) reads the word, then writes it back. In the write-back, only byte lane offset[1:0] for a byte, or lanes 3:2 when offset bit 1 is set and lanes 1:0 when it is clear for a halfword, are replaced with the low write data bytes. A size 2 write is a single write of the full data.
- R9: A read returns the addressed byte (size 0) or halfword (size 1) shifted down to bit 0 with the upper bits zero, or the whole word for size 2. A write responds with data 0.
- R10: busy_o is high from the cycle after acceptance through the response cycle. req_valid_i is ignored while busy_o is high. rsp_valid_o is a single-cycle pulse. mem_req_o holds address and direction until mem_rsp_i.
- R11: rsp_valid_o rises in the cycle after the memory response that completes the last access of the sequence.
- R12: After reset busy_o, rsp_valid_o and mem_req_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| root_bus_i | input | BUS_W | Bus number of the root port |
| req_valid_i | input | 1 | Request strobe, taken when busy_o is low |
| req_we_i | input | 1 | 1 for write, 0 for read |
| req_bus_i | input | BUS_W | Target bus number |
| req_dev_i | input | DEV_W | Target device number |
| req_fn_i | input | FN_W | Target function number |
| req_off_i | input | OFF_W | Byte offset in configuration space |
| req_size_i | input | 2 | 0 byte, 1 halfword, 2 word |
| req_wdata_i | input | 32 | Write data, right aligned |
| busy_o | output | 1 | Request in progress |
| rsp_valid_o | output | 1 | One-cycle completion pulse |
| rsp_rdata_o | output | 32 | Read result, right aligned |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory access is a write |
| mem_addr_o | output | 32 | Memory word address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rsp_i | input | 1 | Memory access complete |
| mem_rdata_i | input | 32 | Memory read data, valid with mem_rsp_i |

## Verification
The memory model in the bench answers each access one cycle after it sees the request, so every access takes two cycles. A request needing n accesses shows rsp_valid_o 2n+1 cycles after the accepting edge. The value of n depends on the target class and the write kind: a rejected request gives n=0, so its response comes one cycle after acceptance. The bench samples at falling edges, counts edges from acceptance to the response and compares that count with 2n+1. It then compares the logged sequence of addresses, directions and write data against a sequence it builds itself from the bus, device, offset and size.

// File: rtl/cfg_xlate_pkg.sv
package cfg_xlate_pkg;
  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2, SZ_WORD2 = 2'd3} size_e;
  typedef enum logic [1:0] {TGT_ROOT, TGT_LOCAL, TGT_REMOTE} tgt_e;
  typedef enum logic [2:0] {S_IDLE, S_VPORT, S_TYPE, S_TGT, S_RD, S_WR, S_RESP} st_e;
  localparam logic [31:0] TYPE_CFG0 = 32'd4;
  localparam logic [31:0] TYPE_CFG1 = 32'd5;
endpackage

// File: rtl/cfg_xlate_route.sv
module cfg_xlate_route
  import cfg_xlate_pkg::*;
#(
  parameter int unsigned BUS_W = 8,
  parameter int unsigned DEV_W = 5,
  parameter int unsigned FN_W  = 3,
  parameter int unsigned OFF_W = 12,
  parameter logic [31:0] CTRL_BASE = 32'hF000_0000,
  parameter logic [31:0] WIN_BASE  = 32'hE000_0000
) (
  input  logic [BUS_W-1:0] root_bus_i,
  input  logic [BUS_W-1:0] bus_i,
  input  logic [DEV_W-1:0] dev_i,
  input  logic [FN_W-1:0]  fn_i,
  input  logic [OFF_W-1:0] off_i,
  output tgt_e             cls_o,
  output logic             reject_o,
  output logic [31:0]      type_o,
  output logic [31:0]      target_o,
  output logic [31:0]      word_addr_o
);
  localparam int unsigned ID_W = BUS_W + DEV_W + FN_W;

  logic [BUS_W-1:0] rel;
  logic [ID_W-1:0]  id;
  logic [31:0]      base;

  assign rel = bus_i - root_bus_i;
  assign id  = {bus_i, dev_i, fn_i};

  always_comb begin
    if (rel == '0)                     cls_o = TGT_ROOT;
    else if (rel == BUS_W'(1))         cls_o = TGT_LOCAL;
    else                               cls_o = TGT_REMOTE;
  end

  // devices beyond 0 on the two nearest buses are unreachable
  assign reject_o    = (cls_o != TGT_REMOTE) && (dev_i != '0);
  assign type_o      = (cls_o == TGT_LOCAL) ? TYPE_CFG0 : TYPE_CFG1;
  assign target_o    = 32'(id) << (32 - ID_W);
  assign base        = (cls_o == TGT_ROOT) ? CTRL_BASE : WIN_BASE;
  assign word_addr_o = base + 32'({off_i[OFF_W-1:2], 2'b00});
endmodule

// File: rtl/cfg_xlate_lane.sv
module cfg_xlate_lane
  import cfg_xlate_pkg::*;
(
  input  size_e       size_i,
  input  logic [1:0]  lo_i,
  input  logic [31:0] rd_word_i,
  input  logic [31:0] old_word_i,
  input  logic [31:0] wr_data_i,
  output logic [31:0] ext_o,
  output logic [31:0] ones_o,
  output logic [31:0] merged_o,
  output logic        full_o
);
  logic [3:0]  be;
  logic [31:0] wrep;
  logic [31:0] shifted;

  assign full_o  = (size_i == SZ_WORD) || (size_i == SZ_WORD2);
  assign shifted = rd_word_i >> {lo_i, 3'b000};

  always_comb begin
    case (size_i)
      SZ_BYTE: begin
        be     = 4'b0001 << lo_i;
        wrep   = {4{wr_data_i[7:0]}};
        ones_o = 32'h0000_00FF;
        ext_o  = {24'h0, shifted[7:0]};
      end
      SZ_HALF: begin
        be     = lo_i[1] ? 4'b1100 : 4'b0011;
        wrep   = {2{wr_data_i[15:0]}};
        ones_o = 32'h0000_FFFF;
        ext_o  = lo_i[1] ? {16'h0, rd_word_i[31:16]} : {16'h0, rd_word_i[15:0]};
      end
      default: begin
        be     = 4'b1111;
        wrep   = wr_data_i;
        ones_o = 32'hFFFF_FFFF;
        ext_o  = rd_word_i;
      end
    endcase
  end

  for (genvar g = 0; g < 4; g++) begin : g_lane
    assign merged_o[8*g +: 8] = be[g] ? wrep[8*g +: 8] : old_word_i[8*g +: 8];
  end
endmodule

// File: rtl/cfg_xlate_seq.sv
module cfg_xlate_seq
  import cfg_xlate_pkg::*;
#(
  parameter logic [31:0] CTRL_BASE  = 32'hF000_0000,
  parameter logic [31:0] VPORT_OFF  = 32'h900,
  parameter logic [31:0] TYPE_OFF   = 32'h904,
  parameter logic [31:0] TARGET_OFF = 32'h918
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  input  logic        we_i,
  input  logic        reject_i,
  input  tgt_e        cls_i,
  input  logic        full_i,
  input  logic [31:0] type_i,
  input  logic [31:0] target_i,
  input  logic [31:0] word_addr_i,
  input  logic [31:0] ones_i,
  input  logic [31:0] ext_i,
  input  logic [31:0] merged_i,
  input  logic [31:0] wr_data_i,
  output logic        accept_o,
  output logic        busy_o,
  output logic [31:0] old_word_o,
  output logic        rsp_valid_o,
  output logic [31:0] rsp_data_o,
  output logic        mem_req_o,
  output logic        mem_we_o,
  output logic [31:0] mem_addr_o,
  output logic [31:0] mem_wdata_o,
  input  logic        mem_rsp_i,
  input  logic [31:0] mem_rdata_i
);
  st_e         st_q, st_d, acc_st;
  logic [31:0] rsp_q;
  logic [31:0] old_q;

  assign acc_st   = (we_i && full_i) ? S_WR : S_RD;
  assign accept_o = (st_q == S_IDLE) && req_valid_i;

  always_comb begin
    st_d = st_q;
    case (st_q)
      S_IDLE:  if (req_valid_i) st_d = reject_i ? S_RESP : S_VPORT;
      S_VPORT: if (mem_rsp_i) st_d = S_TYPE;
      S_TYPE:  if (mem_rsp_i) st_d = (cls_i == TGT_ROOT) ? acc_st : S_TGT;
      S_TGT:   if (mem_rsp_i) st_d = acc_st;
      S_RD:    if (mem_rsp_i) st_d = we_i ? S_WR : S_RESP;
      S_WR:    if (mem_rsp_i) st_d = S_RESP;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= S_IDLE;
      rsp_q <= '0;
      old_q <= '0;
    end else begin
      st_q <= st_d;
      if (accept_o && reject_i) rsp_q <= we_i ? 32'h0 : ones_i;
      if (st_q == S_RD && mem_rsp_i) begin
        old_q <= mem_rdata_i;
        if (!we_i) rsp_q <= ext_i;
      end
      if (st_q == S_WR && mem_rsp_i) rsp_q <= '0;
    end
  end

  always_comb begin
    mem_req_o   = 1'b1;
    mem_we_o    = 1'b1;
    mem_addr_o  = word_addr_i;
    mem_wdata_o = '0;
    case (st_q)
      S_VPORT: mem_addr_o = CTRL_BASE + VPORT_OFF;
      S_TYPE: begin
        mem_addr_o  = CTRL_BASE + TYPE_OFF;
        mem_wdata_o = type_i;
      end
      S_TGT: begin
        mem_addr_o  = CTRL_BASE + TARGET_OFF;
        mem_wdata_o = target_i;
      end
      S_RD:    mem_we_o = 1'b0;
      S_WR:    mem_wdata_o = full_i ? wr_data_i : merged_i;
      default: begin
        mem_req_o = 1'b0;
        mem_we_o  = 1'b0;
      end
    endcase
  end

  assign busy_o      = (st_q != S_IDLE);
  assign rsp_valid_o = (st_q == S_RESP);
  assign rsp_data_o  = rsp_q;
  assign old_word_o  = old_q;
endmodule

// File: rtl/cfg_xlate.sv
module cfg_xlate
  import cfg_xlate_pkg::*;
#(
  parameter int unsigned BUS_W = 8,
  parameter int unsigned DEV_W = 5,
  parameter int unsigned FN_W  = 3,
  parameter int unsigned OFF_W = 12,
  parameter logic [31:0] CTRL_BASE  = 32'hF000_0000,
  parameter logic [31:0] WIN_BASE   = 32'hE000_0000,
  parameter logic [31:0] VPORT_OFF  = 32'h900,
  parameter logic [31:0] TYPE_OFF   = 32'h904,
  parameter logic [31:0] TARGET_OFF = 32'h918
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [BUS_W-1:0] root_bus_i,
  input  logic             req_valid_i,
  input  logic             req_we_i,
  input  logic [BUS_W-1:0] req_bus_i,
  input  logic [DEV_W-1:0] req_dev_i,
  input  logic [FN_W-1:0]  req_fn_i,
  input  logic [OFF_W-1:0] req_off_i,
  input  logic [1:0]       req_size_i,
  input  logic [31:0]      req_wdata_i,
  output logic             busy_o,
  output logic             rsp_valid_o,
  output logic [31:0]      rsp_rdata_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [31:0]      mem_addr_o,
  output logic [31:0]      mem_wdata_o,
  input  logic             mem_rsp_i,
  input  logic [31:0]      mem_rdata_i
);
  logic [BUS_W-1:0] root_q, bus_q;
  logic [DEV_W-1:0] dev_q;
  logic [FN_W-1:0]  fn_q;
  logic [OFF_W-1:0] off_q;
  logic [1:0]       size_q;
  logic             we_q;
  logic [31:0]      wd_q;

  logic [BUS_W-1:0] c_root, c_bus;
  logic [DEV_W-1:0] c_dev;
  logic [FN_W-1:0]  c_fn;
  logic [OFF_W-1:0] c_off;
  logic [1:0]       c_size;
  logic             c_we;
  logic [31:0]      c_wd;

  tgt_e        rt_cls;
  logic        rt_reject;
  logic [31:0] rt_type, rt_target, rt_addr;
  logic [31:0] ln_ext, ln_ones, ln_merged;
  logic        ln_full;
  logic [31:0] old_word;
  logic        seq_accept;

  // live request while idle, held copy while busy
  assign c_root = busy_o ? root_q : root_bus_i;
  assign c_bus  = busy_o ? bus_q  : req_bus_i;
  assign c_dev  = busy_o ? dev_q  : req_dev_i;
  assign c_fn   = busy_o ? fn_q   : req_fn_i;
  assign c_off  = busy_o ? off_q  : req_off_i;
  assign c_size = busy_o ? size_q : req_size_i;
  assign c_we   = busy_o ? we_q   : req_we_i;
  assign c_wd   = busy_o ? wd_q   : req_wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      root_q <= '0;
      bus_q  <= '0;
      dev_q  <= '0;
      fn_q   <= '0;
      off_q  <= '0;
      size_q <= '0;
      we_q   <= 1'b0;
      wd_q   <= '0;
    end else if (seq_accept) begin
      root_q <= root_bus_i;
      bus_q  <= req_bus_i;
      dev_q  <= req_dev_i;
      fn_q   <= req_fn_i;
      off_q  <= req_off_i;
      size_q <= req_size_i;
      we_q   <= req_we_i;
      wd_q   <= req_wdata_i;
    end
  end

  cfg_xlate_route #(
    .BUS_W(BUS_W), .DEV_W(DEV_W), .FN_W(FN_W), .OFF_W(OFF_W),
    .CTRL_BASE(CTRL_BASE), .WIN_BASE(WIN_BASE)
  ) i_route (
    .root_bus_i (c_root),
    .bus_i      (c_bus),
    .dev_i      (c_dev),
    .fn_i       (c_fn),
    .off_i      (c_off),
    .cls_o      (rt_cls),
    .reject_o   (rt_reject),
    .type_o     (rt_type),
    .target_o   (rt_target),
    .word_addr_o(rt_addr)
  );

  cfg_xlate_lane i_lane (
    .size_i    (size_e'(c_size)),
    .lo_i      (c_off[1:0]),
    .rd_word_i (mem_rdata_i),
    .old_word_i(old_word),
    .wr_data_i (c_wd),
    .ext_o     (ln_ext),
    .ones_o    (ln_ones),
    .merged_o  (ln_merged),
    .full_o    (ln_full)
  );

  cfg_xlate_seq #(
    .CTRL_BASE(CTRL_BASE), .VPORT_OFF(VPORT_OFF),
    .TYPE_OFF(TYPE_OFF), .TARGET_OFF(TARGET_OFF)
  ) i_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid_i),
    .we_i       (c_we),
    .reject_i   (rt_reject),
    .cls_i      (rt_cls),
    .full_i     (ln_full),
    .type_i     (rt_type),
    .target_i   (rt_target),
    .word_addr_i(rt_addr),
    .ones_i     (ln_ones),
    .ext_i      (ln_ext),
    .merged_i   (ln_merged),
    .wr_data_i  (c_wd),
    .accept_o   (seq_accept),
    .busy_o     (busy_o),
    .old_word_o (old_word),
    .rsp_valid_o(rsp_valid_o),
    .rsp_data_o (rsp_rdata_o),
    .mem_req_o  (mem_req_o),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .mem_wdata_o(mem_wdata_o),
    .mem_rsp_i  (mem_rsp_i),
    .mem_rdata_i(mem_rdata_i)
  );
endmodule

// File: rtl/cfg_xlate_chk.sv
module cfg_xlate_chk #(
  parameter logic [31:0] CTRL_BASE = 32'hF000_0000,
  parameter logic [31:0] VPORT_OFF = 32'h900,
  parameter logic [31:0] TYPE_OFF  = 32'h904
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        accept_i,
  input logic        reject_i,
  input logic        busy_o,
  input logic        rsp_valid_o,
  input logic        mem_req_o,
  input logic        mem_we_o,
  input logic [31:0] mem_addr_o,
  input logic [31:0] mem_wdata_o,
  input logic        mem_rsp_i
);
  AST_REJECT_NO_MEM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i && reject_i |=> rsp_valid_o && !mem_req_o);  // R6

  AST_VPORT_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i && !reject_i |=> mem_req_o && mem_we_o &&
      mem_addr_o == CTRL_BASE + VPORT_OFF && mem_wdata_o == 32'h0);  // R5

  AST_TYPE_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o && mem_addr_o == CTRL_BASE + TYPE_OFF |->
      (mem_wdata_o == 32'd4 || mem_wdata_o == 32'd5));  // R2

  AST_MEM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_rsp_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));  // R10

  AST_RSP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);  // R10

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o && !rsp_valid_o);  // R10

  AST_DONE_TO_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_rsp_i && !$past(mem_rsp_i) |=> rsp_valid_o || mem_req_o);  // R11
endmodule

bind cfg_xlate cfg_xlate_chk #(
  .CTRL_BASE(CTRL_BASE), .VPORT_OFF(VPORT_OFF), .TYPE_OFF(TYPE_OFF)
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .accept_i   (seq_accept),
  .reject_i   (rt_reject),
  .busy_o     (busy_o),
  .rsp_valid_o(rsp_valid_o),
  .mem_req_o  (mem_req_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .mem_wdata_o(mem_wdata_o),
  .mem_rsp_i  (mem_rsp_i)
);

// File: tb/test_cfg_xlate.sv
`timescale 1ns/1ps
module test_cfg_xlate;
  localparam logic [31:0] CB = 32'hF000_0000;
  localparam logic [31:0] WB = 32'hE000_0000;
  localparam logic [31:0] VP = 32'h900;
  localparam logic [31:0] TY = 32'h904;
  localparam logic [31:0] TG = 32'h918;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  root_bus = '0;
  logic        req_valid = 1'b0, req_we = 1'b0;
  logic [7:0]  req_bus = '0;
  logic [4:0]  req_dev = '0;
  logic [2:0]  req_fn = '0;
  logic [11:0] req_off = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        busy, rsp_valid;
  logic [31:0] rsp_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_rsp = 1'b0;
  logic [31:0] mem_rdata = '0;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [31:0] ctrl_mem [1024];
  logic [31:0] win_mem [1024];
  logic [31:0] lg_addr [8];
  logic        lg_we [8];
  logic [31:0] lg_data [8];
  int          op_n = 0;

  always #10 clk = ~clk;

  cfg_xlate i_cfg_xlate (
    .clk_i(clk), .rst_ni(rst_n), .root_bus_i(root_bus),
    .req_valid_i(req_valid), .req_we_i(req_we), .req_bus_i(req_bus),
    .req_dev_i(req_dev), .req_fn_i(req_fn), .req_off_i(req_off),
    .req_size_i(req_size), .req_wdata_i(req_wdata),
    .busy_o(busy), .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rsp_i(mem_rsp), .mem_rdata_i(mem_rdata)
  );

  // memory model: answers one cycle after seeing a request
  always @(posedge clk) begin
    if (mem_req && !mem_rsp) begin
      mem_rsp <= 1'b1;
      if (op_n < 8) begin
        lg_addr[op_n] = mem_addr;
        lg_we[op_n]   = mem_we;
        lg_data[op_n] = mem_wdata;
      end
      op_n = op_n + 1;
      if (mem_we) begin
        if (mem_addr[31:12] == CB[31:12]) ctrl_mem[mem_addr[11:2]] = mem_wdata;
        else if (mem_addr[31:12] == WB[31:12]) win_mem[mem_addr[11:2]] = mem_wdata;
      end else begin
        if (mem_addr[31:12] == CB[31:12]) mem_rdata <= ctrl_mem[mem_addr[11:2]];
        else if (mem_addr[31:12] == WB[31:12]) mem_rdata <= win_mem[mem_addr[11:2]];
        else mem_rdata <= 32'hDEAD_BEEF;
      end
    end else begin
      mem_rsp <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
    end
  endtask

  task automatic do_req(input logic [7:0] bus, input logic [4:0] dev, input logic [2:0] fn,
                        input logic [11:0] off, input logic [1:0] size, input bit we,
                        input logic [31:0] wd);
    logic [31:0] e_addr [8];
    logic        e_we [8];
    logic [31:0] e_data [8];
    logic [31:0] waddr, old, merged, exp_rd, ones;
    logic [3:0]  be;
    logic [31:0] wrep;
    int n = 0, cnt;
    bit is_root, is_loc, rej;
    string rq;
    is_root = (bus == root_bus);
    is_loc  = (bus == 8'(root_bus + 8'd1));
    rej     = (is_root || is_loc) && dev != 0;
    waddr   = (is_root ? CB : WB) + {20'h0, off[11:2], 2'b00};
    old     = is_root ? ctrl_mem[off[11:2]] : win_mem[off[11:2]];
    ones    = (size == 0) ? 32'hFF : (size == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
    be      = (size == 0) ? (4'b0001 << off[1:0]) : (size == 1) ? (off[1] ? 4'b1100 : 4'b0011) : 4'b1111;
    wrep    = (size == 0) ? wd[7:0] << (8 * off[1:0]) : (size == 1) ? wd[15:0] << (16 * off[1]) : wd;
    for (int b = 0; b < 4; b++) merged[8*b +: 8] = be[b] ? wrep[8*b +: 8] : old[8*b +: 8];
    exp_rd  = (size == 0) ? ((old >> (8 * off[1:0])) & 32'hFF) :
              (size == 1) ? ((old >> (16 * off[1])) & 32'hFFFF) : old;
    if (rej) exp_rd = we ? 32'h0 : ones;
    else if (we) exp_rd = 32'h0;
    if (!rej) begin
      e_addr[n] = CB + VP; e_we[n] = 1; e_data[n] = 0; n++;                          // R5
      e_addr[n] = CB + TY; e_we[n] = 1; e_data[n] = is_loc ? 32'd4 : 32'd5; n++;      // R1 R2 R3
      if (!is_root) begin e_addr[n] = CB + TG; e_we[n] = 1; e_data[n] = {bus, dev, fn, 16'h0}; n++; end // R4
      if (!we || size < 2) begin e_addr[n] = waddr; e_we[n] = 0; e_data[n] = 0; n++; end            // R7
      if (we) begin e_addr[n] = waddr; e_we[n] = 1; e_data[n] = (size < 2) ? merged : wd; n++; end  // R8
    end
    rq = rej ? "R6" : is_loc ? "R2" : is_root ? "R1" : "R3";
    @(negedge clk);
    op_n = 0;
    req_valid = 1; req_we = we; req_bus = bus; req_dev = dev; req_fn = fn;
    req_off = off; req_size = size; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    cnt = 1;
    while (!rsp_valid && cnt < 40) begin @(negedge clk); cnt++; end
    chk(cnt == 2 * n + 1, "R11", "latency", 32'(cnt), 32'(2 * n + 1));
    chk(rsp_rdata == exp_rd, we ? "R8" : (rej ? "R6" : "R9"), "rdata", rsp_rdata, exp_rd);
    chk(op_n == n, rq, "op count", 32'(op_n), 32'(n));
    for (int i = 0; i < n && i < op_n; i++) begin
      chk(lg_addr[i] == e_addr[i] && lg_we[i] == e_we[i], rq, "op addr", lg_addr[i], e_addr[i]);
      if (e_we[i]) chk(lg_data[i] == e_data[i], rq, "op wdata", lg_data[i], e_data[i]);
    end
    @(negedge clk);
    chk(!rsp_valid && !busy, "R10", "idle after rsp", {30'h0, rsp_valid, busy}, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    automatic logic [7:0]  rb [2] = '{8'h10, 8'hFF};
    automatic logic [4:0]  dv [3] = '{5'd0, 5'd1, 5'd31};
    automatic logic [11:0] of [6] = '{12'h000, 12'h001, 12'h002, 12'h003, 12'h135, 12'h7FC};
    for (int i = 0; i < 1024; i++) begin
      ctrl_mem[i] = 32'h1000_0000 + i * 32'h0103_0507;
      win_mem[i]  = 32'h8000_0000 + i * 32'h0709_0B0D;
    end
    repeat (3) @(negedge clk);
    chk(!busy && !rsp_valid && !mem_req, "R12", "reset outputs", {29'h0, busy, rsp_valid, mem_req}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !rsp_valid && !mem_req, "R12", "after release", {29'h0, busy, rsp_valid, mem_req}, 0);

    for (int r = 0; r < 2; r++) begin
      root_bus = rb[r];
      for (int bi = 0; bi < 4; bi++) begin
        automatic logic [7:0] bus = (bi == 0) ? rb[r] : (bi == 1) ? 8'(rb[r] + 1) :
                                    (bi == 2) ? 8'(rb[r] + 2) : 8'(rb[r] - 1);
        for (int d = 0; d < 3; d++)
          for (int f = 0; f < 8; f += 5)
            for (int s = 0; s < 3; s++)
              for (int o = 0; o < 6; o++)
                for (int w = 0; w < 2; w++)
                  do_req(bus, dv[d], 3'(f), of[o], 2'(s), w[0],
                         32'hA1B2_C3D4 ^ (32'(bi * 97 + d * 13 + s * 7 + o) << 8));
      end
    end

    // R10: request held during busy is not taken
    root_bus = 8'h10;
    @(negedge clk);
    op_n = 0;
    req_valid = 1; req_we = 0; req_bus = 8'h12; req_dev = 0; req_fn = 0;
    req_off = 12'h010; req_size = 2;
    @(negedge clk);
    req_bus = 8'h10; req_dev = 5'd3;
    while (!rsp_valid) @(negedge clk);
    req_valid = 0;
    chk(rsp_rdata == win_mem[4], "R10", "first request data", rsp_rdata, win_mem[4]);
    repeat (4) @(negedge clk);
    chk(!rsp_valid && !busy && op_n == 4, "R10", "no second request", 32'(op_n), 32'd4);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule